// File: doc/BRIEF.md
# Thread-Shared Fully Associative Translation Buffer

This block is a first-level address translation cache shared by the two hardware threads of a simultaneous multithreading core. It holds a small pool of entries, and any entry can cache any translation. Each entry pairs an address-space tag and a virtual page number with a physical page number, a set of permission bits, a page-size code and a global flag. The virtual page number compare and the physical address assembly both follow the entry's page size, which can be 4 KiB, 2 MiB or 1 GiB. A lookup is purely combinational against the registered entries, so hit, physical address and permissions come back in the same cycle as the request.

The two threads share the storage. They are kept apart by widening the address-space tag with one bit that takes the requesting thread's id. A configuration input can instead let both threads present the full-width tag as a system-wide value. A fill port installs a translation. It takes a free slot when one exists and otherwise evicts a pseudo-random one. A flush port removes translations, either all of them or only those selected by tag, by virtual page, or by both.

Top module: `tlb_smt`

## Requirements
- R1: A synchronous active-high reset invalidates every entry and loads the pseudo-random generator with 16'hACE1. No lookup hits until a fill has been written.
- R2: A lookup whose effective tag and virtual page match a valid 4 KiB entry raises `lk_hit` in the same cycle. `lk_pa` is the stored page number followed by `lk_va[11:0]`, and `lk_perm` is the stored permission field.
- R3: Size code 1 (2 MiB) compares only virtual page bits [26:9] and takes `lk_va[20:0]` as the offset. Size code 2 (1 GiB) compares only bits [26:18] and takes `lk_va[29:0]` as the offset. Codes 0 and 3 mean 4 KiB.
- R4: While `share_asid` is 0, the effective tag is {thread id, low 9 tag bits}, so an entry filled by one thread never hits for the other thread.
- R5: While `share_asid` is 1, the effective tag is the full 10-bit tag input, and either thread hits an entry that the other thread filled with the same tag.
- R6: An entry filled with `fill_global` set matches any tag from either thread.
- R7: A fill writes the lowest-numbered invalid entry whenever one exists.
- R8: When every entry is valid, a fill replaces entry (generator state mod entry count). The generator is a 16-bit left-shifting register whose new bit 0 is s[15]^s[13]^s[12]^s[10], and it advances on every cycle out of reset.
- R9: A flush with neither qualifier set invalidates every entry.
- R10: A flush with only the tag qualifier set invalidates the non-global entries whose stored tag equals the flush's effective tag. Global entries survive.
- R11: A flush with the page qualifier set invalidates the entries whose size-masked page covers `flush_vpn`, restricted to the matching non-global tag when the tag qualifier is also set.
- R12: A lookup in the same cycle as a fill sees the contents from before that fill. The new entry hits from the next cycle.
- R13: When several entries match, the lowest-numbered one supplies the result. On a miss, `lk_pa` and `lk_perm` are zero.
- R14: When a flush and a fill occur in the same cycle, the flush is applied first and the fill's entry is valid afterwards. The slot is chosen from the validity before the flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| share_asid | input | 1 | Use the full-width tag for both threads |
| lk_tid | input | 1 | Thread issuing the lookup |
| lk_asid | input | 10 | Lookup address-space tag |
| lk_va | input | 39 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | 56 | Translated physical address |
| lk_perm | output | 6 | Permission bits of the hit entry |
| fill_en | input | 1 | Install a translation this cycle |
| fill_tid | input | 1 | Thread installing the translation |
| fill_asid | input | 10 | Tag of the new translation |
| fill_vpn | input | 27 | Virtual page number |
| fill_ppn | input | 44 | Physical page number |
| fill_size | input | 2 | Page size code (0 4 KiB, 1 2 MiB, 2 1 GiB) |
| fill_global | input | 1 | Entry ignores the tag |
| fill_perm | input | 6 | Permission bits |
| flush_en | input | 1 | Flush request this cycle |
| flush_tid | input | 1 | Thread issuing the flush |
| flush_asid | input | 10 | Flush tag qualifier value |
| flush_by_asid | input | 1 | Restrict the flush to one tag |
| flush_by_va | input | 1 | Restrict the flush to one virtual page |
| flush_vpn | input | 27 | Flush virtual page number |

## Verification
The bench targets cross-thread aliasing. A tag compare that dropped the thread bit would let thread 1 hit thread 0's page, and one that kept the bit in shared mode would miss a legitimately shared page. It targets superpages by looking up addresses far inside them: a wrong mask would either miss, or splice virtual offset bits into the wrong part of the physical address. The flush variants are mixed with global entries, so a flush that cleared too much would lose kernel mappings and one that cleared too little would leave a stale hit. It also covers the full-buffer fill, where a wrong slot choice evicts a live translation the reference still expects to hit, and the same-cycle fill/lookup and flush/fill orderings.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int OFF_W   = 12;
    localparam int LVL_W   = 9;
    localparam int VPN_W   = 3 * LVL_W;
    localparam int VA_W    = VPN_W + OFF_W;
    localparam int PPN_W   = 44;
    localparam int PA_W    = PPN_W + OFF_W;
    localparam int ASID_W  = 9;
    localparam int EASID_W = ASID_W + 1;
    localparam int PERM_W  = 6;
    localparam int LFSR_W  = 16;

    typedef enum logic [1:0] {
        PG_4K = 2'd0,
        PG_2M = 2'd1,
        PG_1G = 2'd2,
        PG_RSV = 2'd3
    } pg_size_e;

    typedef struct packed {
        logic                  global;
        pg_size_e              size;
        logic [EASID_W-1:0]    asid;
        logic [VPN_W-1:0]      vpn;
        logic [PPN_W-1:0]      ppn;
        logic [PERM_W-1:0]     perm;
    } tlb_entry_t;

    // Page-number bits that take part in a compare for a given size.
    function automatic logic [VPN_W-1:0] vpn_cmp_mask(pg_size_e sz);
        logic [VPN_W-1:0] m;
        m = '1;
        case (sz)
            PG_2M:   m = m << LVL_W;
            PG_1G:   m = m << (2 * LVL_W);
            default: m = '1;
        endcase
        return m;
    endfunction

    // Physical-address bits taken from the virtual offset.
    function automatic logic [PA_W-1:0] pa_off_mask(pg_size_e sz);
        logic [PA_W-1:0] m;
        case (sz)
            PG_2M:   m = (PA_W'(1) << (OFF_W + LVL_W)) - PA_W'(1);
            PG_1G:   m = (PA_W'(1) << (OFF_W + 2 * LVL_W)) - PA_W'(1);
            default: m = (PA_W'(1) << OFF_W) - PA_W'(1);
        endcase
        return m;
    endfunction

    function automatic logic [PA_W-1:0] build_pa(logic [PPN_W-1:0] ppn,
                                                 pg_size_e sz,
                                                 logic [VA_W-1:0] va);
        logic [PA_W-1:0] base;
        logic [PA_W-1:0] m;
        base = {ppn, {OFF_W{1'b0}}};
        m    = pa_off_mask(sz);
        return (base & ~m) | ({{(PA_W - VA_W){1'b0}}, va} & m);
    endfunction

    // Thread-qualified tag unless sharing is enabled.
    function automatic logic [EASID_W-1:0] eff_asid(logic tid,
                                                    logic [EASID_W-1:0] asid,
                                                    logic share);
        return share ? asid : {tid, asid[ASID_W-1:0]};
    endfunction

endpackage

// File: rtl/tlb_lfsr.sv
module tlb_lfsr #(
    parameter int             W    = 16,
    parameter logic [W-1:0]   SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] state
);
    logic fb;

    assign fb = state[W-1] ^ state[W-3] ^ state[W-4] ^ state[W-6];

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEED;
        end else begin
            state <= {state[W-2:0], fb};
        end
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int N     = 32,
    parameter int RND_W = 16,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     valid,
    input  logic [RND_W-1:0] rnd,
    output logic [IDX_W-1:0] victim
);
    logic [IDX_W-1:0] free_idx;
    logic             any_free;

    always_comb begin
        free_idx = '0;
        any_free = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_idx = IDX_W'(i);
                any_free = 1'b1;
            end
        end
    end

    assign victim = any_free ? free_idx : IDX_W'(32'(rnd) % N);
endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
(
    input  tlb_entry_t          entry,
    input  logic                entry_valid,
    input  logic [EASID_W-1:0]  lk_easid,
    input  logic [VPN_W-1:0]    lk_vpn,
    input  logic                fl_en,
    input  logic                fl_by_asid,
    input  logic                fl_by_va,
    input  logic [EASID_W-1:0]  fl_easid,
    input  logic [VPN_W-1:0]    fl_vpn,
    output logic                lk_hit,
    output logic                fl_kill
);
    logic [VPN_W-1:0] m;
    logic             lk_page_eq;
    logic             fl_page_eq;
    logic             fl_tag_eq;

    assign m          = vpn_cmp_mask(entry.size);
    assign lk_page_eq = ((entry.vpn ^ lk_vpn) & m) == '0;
    assign fl_page_eq = ((entry.vpn ^ fl_vpn) & m) == '0;
    assign fl_tag_eq  = !entry.global && (entry.asid == fl_easid);

    assign lk_hit = entry_valid && lk_page_eq
                    && (entry.global || entry.asid == lk_easid);

    always_comb begin
        fl_kill = 1'b0;
        if (fl_en && entry_valid) begin
            if (!fl_by_asid && !fl_by_va) begin
                fl_kill = 1'b1;
            end else begin
                fl_kill = (!fl_by_va || fl_page_eq) && (!fl_by_asid || fl_tag_eq);
            end
        end
    end
endmodule

// File: rtl/tlb_smt.sv
module tlb_smt
    import tlb_pkg::*;
#(
    parameter int                NUM_ENTRIES = 32,
    parameter logic [LFSR_W-1:0] LFSR_SEED   = 16'hACE1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                share_asid,
    input  logic                lk_tid,
    input  logic [EASID_W-1:0]  lk_asid,
    input  logic [VA_W-1:0]     lk_va,
    output logic                lk_hit,
    output logic [PA_W-1:0]     lk_pa,
    output logic [PERM_W-1:0]   lk_perm,
    input  logic                fill_en,
    input  logic                fill_tid,
    input  logic [EASID_W-1:0]  fill_asid,
    input  logic [VPN_W-1:0]    fill_vpn,
    input  logic [PPN_W-1:0]    fill_ppn,
    input  logic [1:0]          fill_size,
    input  logic                fill_global,
    input  logic [PERM_W-1:0]   fill_perm,
    input  logic                flush_en,
    input  logic                flush_tid,
    input  logic [EASID_W-1:0]  flush_asid,
    input  logic                flush_by_asid,
    input  logic                flush_by_va,
    input  logic [VPN_W-1:0]    flush_vpn
);
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

    logic [NUM_ENTRIES-1:0] valid_q;
    tlb_entry_t             entries_q [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] hit_vec;
    logic [NUM_ENTRIES-1:0] kill_vec;
    logic [NUM_ENTRIES-1:0] fill_onehot;
    logic [LFSR_W-1:0]      lfsr_q;
    logic [IDX_W-1:0]       victim_idx;
    logic [EASID_W-1:0]     lk_easid;
    logic [EASID_W-1:0]     fl_easid;
    tlb_entry_t             new_entry;
    tlb_entry_t             sel_entry;
    logic                   any_hit;

    assign lk_easid = eff_asid(lk_tid, lk_asid, share_asid);
    assign fl_easid = eff_asid(flush_tid, flush_asid, share_asid);

    tlb_lfsr #(.W(LFSR_W), .SEED(LFSR_SEED)) u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .state (lfsr_q)
    );

    tlb_victim #(.N(NUM_ENTRIES), .RND_W(LFSR_W)) u_victim (
        .valid  (valid_q),
        .rnd    (lfsr_q),
        .victim (victim_idx)
    );

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
        tlb_match u_match (
            .entry       (entries_q[g]),
            .entry_valid (valid_q[g]),
            .lk_easid    (lk_easid),
            .lk_vpn      (lk_va[VA_W-1:OFF_W]),
            .fl_en       (flush_en),
            .fl_by_asid  (flush_by_asid),
            .fl_by_va    (flush_by_va),
            .fl_easid    (fl_easid),
            .fl_vpn      (flush_vpn),
            .lk_hit      (hit_vec[g]),
            .fl_kill     (kill_vec[g])
        );
        assign fill_onehot[g] = fill_en && (victim_idx == IDX_W'(g));
    end

    // Lowest matching slot wins.
    always_comb begin
        any_hit   = 1'b0;
        sel_entry = entries_q[0];
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any_hit   = 1'b1;
                sel_entry = entries_q[i];
            end
        end
    end

    assign lk_hit  = any_hit;
    assign lk_pa   = any_hit ? build_pa(sel_entry.ppn, sel_entry.size, lk_va) : '0;
    assign lk_perm = any_hit ? sel_entry.perm : '0;

    always_comb begin
        new_entry.global = fill_global;
        new_entry.size   = pg_size_e'(fill_size);
        new_entry.asid   = eff_asid(fill_tid, fill_asid, share_asid);
        new_entry.vpn    = fill_vpn;
        new_entry.ppn    = fill_ppn;
        new_entry.perm   = fill_perm;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else begin
            valid_q <= (valid_q & ~kill_vec) | fill_onehot;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            entries_q[victim_idx] <= new_entry;
        end
    end
endmodule

// File: rtl/tlb_smt_chk.sv
module tlb_smt_chk
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 32,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input logic                   clk,
    input logic                   rst,
    input logic [VA_W-1:0]        lk_va,
    input logic                   lk_hit,
    input logic [PA_W-1:0]        lk_pa,
    input logic [PERM_W-1:0]      lk_perm,
    input logic                   fill_en,
    input logic                   flush_en,
    input logic                   flush_by_asid,
    input logic                   flush_by_va,
    input logic [NUM_ENTRIES-1:0] valid_vec,
    input logic [IDX_W-1:0]       victim,
    input logic [LFSR_W-1:0]      lfsr
);
    p_reset_empty_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (valid_vec == '0));

    p_page_offset_r2: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (lk_pa[OFF_W-1:0] == lk_va[OFF_W-1:0]));

    p_free_slot_r7: assert property (@(posedge clk) disable iff (rst)
        (fill_en && !(&valid_vec)) |-> !valid_vec[victim]);

    p_rand_slot_r8: assert property (@(posedge clk) disable iff (rst)
        (fill_en && (&valid_vec)) |-> (victim == IDX_W'(32'(lfsr) % NUM_ENTRIES)));

    p_lfsr_live_r8: assert property (@(posedge clk) disable iff (rst)
        lfsr != '0);

    p_flush_all_r9: assert property (@(posedge clk) disable iff (rst)
        (flush_en && !flush_by_asid && !flush_by_va && !fill_en) |=> ($countones(valid_vec) == 0));

    p_fill_visible_r12: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> (valid_vec != '0));

    p_miss_zero_r13: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_pa == '0 && lk_perm == '0));
endmodule

bind tlb_smt tlb_smt_chk #(.NUM_ENTRIES(NUM_ENTRIES)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .lk_va         (lk_va),
    .lk_hit        (lk_hit),
    .lk_pa         (lk_pa),
    .lk_perm       (lk_perm),
    .fill_en       (fill_en),
    .flush_en      (flush_en),
    .flush_by_asid (flush_by_asid),
    .flush_by_va   (flush_by_va),
    .valid_vec     (valid_q),
    .victim        (victim_idx),
    .lfsr          (lfsr_q)
);

// File: tb/tlb_smt_tb.sv
`timescale 1ns/1ps
module tlb_smt_tb_top;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        share_asid = 1'b0;
    logic        lk_tid = 1'b0;
    logic [9:0]  lk_asid = '0;
    logic [38:0] lk_va = '0;
    logic        lk_hit;
    logic [55:0] lk_pa;
    logic [5:0]  lk_perm;
    logic        fill_en = 1'b0;
    logic        fill_tid = 1'b0;
    logic [9:0]  fill_asid = '0;
    logic [26:0] fill_vpn = '0;
    logic [43:0] fill_ppn = '0;
    logic [1:0]  fill_size = '0;
    logic        fill_global = 1'b0;
    logic [5:0]  fill_perm = '0;
    logic        flush_en = 1'b0;
    logic        flush_tid = 1'b0;
    logic [9:0]  flush_asid = '0;
    logic        flush_by_asid = 1'b0;
    logic        flush_by_va = 1'b0;
    logic [26:0] flush_vpn = '0;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    tlb_smt dut_i (.*);

    // Behavioural reference state
    bit          m_v   [N];
    bit          m_g   [N];
    int          m_sh  [N];
    logic [9:0]  m_tag [N];
    logic [26:0] m_vpn [N];
    logic [43:0] m_ppn [N];
    logic [5:0]  m_prm [N];
    logic [15:0] m_rng;

    function automatic logic [9:0] tag_of(logic tid, logic [9:0] a);
        return share_asid ? a : {tid, a[8:0]};
    endfunction

    function automatic int shift_of(logic [1:0] sz);
        if (sz == 2'd1) return 9;
        if (sz == 2'd2) return 18;
        return 0;
    endfunction

    task automatic model_lookup(output logic h, output logic [55:0] pa, output logic [5:0] pr);
        logic [9:0] t;
        logic [63:0] full;
        t = tag_of(lk_tid, lk_asid);
        h = 1'b0; pa = '0; pr = '0;
        for (int i = 0; i < N; i++) begin
            if (!h && m_v[i] && ((m_vpn[i] >> m_sh[i]) == (lk_va[38:12] >> m_sh[i]))
                && (m_g[i] || m_tag[i] == t)) begin
                h = 1'b1;
                full = ((64'(m_ppn[i]) >> m_sh[i]) << (12 + m_sh[i]))
                       | (64'(lk_va) & ((64'd1 << (12 + m_sh[i])) - 64'd1));
                pa = full[55:0];
                pr = m_prm[i];
            end
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) m_v[i] = 1'b0;
            m_rng = 16'hACE1;
        end else begin
            int slot;
            slot = -1;
            for (int i = N - 1; i >= 0; i--) if (!m_v[i]) slot = i;
            if (slot < 0) slot = int'(m_rng) % N;
            if (flush_en) begin
                for (int i = 0; i < N; i++) begin
                    bit page_ok, tag_ok;
                    page_ok = (m_vpn[i] >> m_sh[i]) == (flush_vpn >> m_sh[i]);
                    tag_ok  = !m_g[i] && (m_tag[i] == tag_of(flush_tid, flush_asid));
                    if ((!flush_by_asid || tag_ok) && (!flush_by_va || page_ok)) m_v[i] = 1'b0;
                end
            end
            if (fill_en) begin
                m_v[slot]   = 1'b1;
                m_g[slot]   = fill_global;
                m_sh[slot]  = shift_of(fill_size);
                m_tag[slot] = tag_of(fill_tid, fill_asid);
                m_vpn[slot] = fill_vpn;
                m_ppn[slot] = fill_ppn;
                m_prm[slot] = fill_perm;
            end
            m_rng = {m_rng[14:0], m_rng[15] ^ m_rng[13] ^ m_rng[12] ^ m_rng[10]};
        end
    end

    task automatic tick(input string lbl);
        logic eh; logic [55:0] ep; logic [5:0] er;
        #1;
        model_lookup(eh, ep, er);
        checks++;
        if (lk_hit !== eh || lk_pa !== ep || lk_perm !== er) begin
            fails++;
            $display("FAIL %s: hit/pa/perm got %0b/%h/%h expected %0b/%h/%h",
                     lbl, lk_hit, lk_pa, lk_perm, eh, ep, er);
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic look(input logic tid, input logic [9:0] a, input logic [38:0] va, input string lbl);
        lk_tid = tid; lk_asid = a; lk_va = va;
        tick(lbl);
    endtask

    // Fill, probing the same address in that cycle and the next (R12).
    task automatic fill(input logic tid, input logic [9:0] a, input logic [26:0] vpn,
                        input logic [43:0] ppn, input logic [1:0] sz, input logic g,
                        input logic [5:0] pr, input string lbl);
        fill_en = 1'b1; fill_tid = tid; fill_asid = a; fill_vpn = vpn;
        fill_ppn = ppn; fill_size = sz; fill_global = g; fill_perm = pr;
        lk_tid = tid; lk_asid = a; lk_va = {vpn, 12'h5A4};
        tick({lbl, " R12 same-cycle"});
        fill_en = 1'b0;
        tick({lbl, " R12 next-cycle"});
    endtask

    task automatic flush(input logic ba, input logic bv, input logic tid,
                         input logic [9:0] a, input logic [26:0] vpn, input string lbl);
        flush_en = 1'b1; flush_by_asid = ba; flush_by_va = bv;
        flush_tid = tid; flush_asid = a; flush_vpn = vpn;
        tick(lbl);
        flush_en = 1'b0; flush_by_asid = 1'b0; flush_by_va = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        look(0, 10'h005, 39'h12345678, "R1 during reset");
        look(0, 10'h005, 39'h12345678, "R1 during reset");
        rst = 1'b0;
        look(0, 10'h005, 39'h12345678, "R1 after reset");
        look(1, 10'h000, 39'h0, "R1 after reset");

        // R2 base page
        fill(0, 10'h005, 27'h0123, 44'hABCDE, 2'd0, 0, 6'h0B, "R2 fill 4K");
        look(0, 10'h005, {27'h0123, 12'hFFF}, "R2 4K hit");
        look(0, 10'h005, {27'h0124, 12'h000}, "R2 neighbour miss");
        look(0, 10'h006, {27'h0123, 12'h010}, "R2 wrong tag miss");
        // R4 thread isolation
        look(1, 10'h005, {27'h0123, 12'h010}, "R4 other thread miss");
        look(1, 10'h205, {27'h0123, 12'h010}, "R4 other thread high tag bit miss");
        fill(1, 10'h005, 27'h0123, 44'h11111, 2'd0, 0, 6'h07, "R4 thread1 fill");
        look(0, 10'h005, {27'h0123, 12'h010}, "R4 thread0 keeps own");
        look(1, 10'h005, {27'h0123, 12'h010}, "R4 thread1 sees own");

        // R5 shared tags
        share_asid = 1'b1;
        fill(0, 10'h203, 27'h0777, 44'h22222, 2'd0, 0, 6'h03, "R5 shared fill");
        look(1, 10'h203, {27'h0777, 12'h044}, "R5 other thread hit");
        look(1, 10'h003, {27'h0777, 12'h044}, "R5 high bit counts");
        share_asid = 1'b0;

        // R3 superpages
        fill(0, 10'h009, 27'h0400200, 44'h3_0000_0400, 2'd1, 0, 6'h0F, "R3 fill 2M");
        look(0, 10'h009, {27'h04003FF, 12'h123}, "R3 2M deep offset");
        look(0, 10'h009, {27'h0400400, 12'h123}, "R3 2M outside miss");
        fill(0, 10'h009, 27'h1C00000, 44'h0_0000_C0000, 2'd2, 0, 6'h1F, "R3 fill 1G");
        look(0, 10'h009, {27'h1C3FFFF, 12'hABC}, "R3 1G deep offset");
        look(0, 10'h009, {27'h1C40000, 12'hABC}, "R3 1G outside miss");
        fill(0, 10'h009, 27'h0005555, 44'h33333, 2'd3, 0, 6'h01, "R3 code3 as 4K");
        look(0, 10'h009, {27'h0005556, 12'h0}, "R3 code3 neighbour miss");

        // R6 global
        fill(0, 10'h011, 27'h2000, 44'h44444, 2'd0, 1, 6'h21, "R6 global fill");
        look(1, 10'h1F0, {27'h2000, 12'h8}, "R6 any thread any tag");

        // R13 duplicate priority
        fill(0, 10'h033, 27'h3000, 44'h55555, 2'd0, 0, 6'h02, "R13 first copy");
        fill(0, 10'h033, 27'h3000, 44'h66666, 2'd0, 0, 6'h04, "R13 second copy");
        look(0, 10'h033, {27'h3000, 12'h1}, "R13 lowest slot wins");

        // R10 flush by tag keeps global
        fill(0, 10'h011, 27'h2100, 44'h77777, 2'd0, 0, 6'h05, "R10 tagged fill");
        flush(1, 0, 0, 10'h011, 27'h0, "R10 flush tag");
        look(0, 10'h011, {27'h2100, 12'h0}, "R10 tagged gone");
        look(0, 10'h011, {27'h2000, 12'h0}, "R10 global kept");
        look(0, 10'h005, {27'h0123, 12'h0}, "R10 other tag kept");

        // R11 flush by page
        flush(0, 1, 0, 10'h0, 27'h04003AA, "R11 flush page in 2M");
        look(0, 10'h009, {27'h0400201, 12'h0}, "R11 2M gone");
        look(0, 10'h009, {27'h1C00001, 12'h0}, "R11 1G kept");
        flush(1, 1, 0, 10'h005, 27'h0123, "R11 page+tag");
        look(0, 10'h005, {27'h0123, 12'h0}, "R11 thread0 gone");
        look(1, 10'h005, {27'h0123, 12'h0}, "R11 thread1 kept");
        flush(1, 1, 0, 10'h011, 27'h2000, "R11 page+tag keeps global");
        look(0, 10'h011, {27'h2000, 12'h0}, "R11 global survives");

        // R9 flush all
        flush(0, 0, 0, 10'h0, 27'h0, "R9 flush all");
        look(0, 10'h011, {27'h2000, 12'h0}, "R9 global gone");
        look(0, 10'h009, {27'h1C00001, 12'h0}, "R9 1G gone");

        // R7 and R8 fill order and random replacement
        for (int i = 0; i < N; i++)
            fill(i[0], 10'h040, 27'(100 + i), 44'(1000 + i), 2'd0, 0, 6'(i), "R7 fill free");
        flush(0, 1, 0, 10'h0, 27'(110), "R7 open slot");
        fill(0, 10'h040, 27'd600, 44'd6000, 2'd0, 0, 6'h3F, "R7 refill hole");
        fill(1, 10'h040, 27'd700, 44'd7000, 2'd0, 0, 6'h3E, "R8 random evict");
        fill(0, 10'h040, 27'd701, 44'd7001, 2'd0, 0, 6'h3D, "R8 random evict 2");
        for (int i = 0; i < N; i++)
            look(i[0], 10'h040, {27'(100 + i), 12'h0}, "R8 survivors");
        look(0, 10'h040, {27'd600, 12'h0}, "R7 hole entry");

        // R14 flush and fill together
        fill_en = 1'b1; fill_tid = 0; fill_asid = 10'h077; fill_vpn = 27'h4444;
        fill_ppn = 44'h88888; fill_size = 2'd0; fill_global = 0; fill_perm = 6'h09;
        flush(0, 0, 0, 10'h0, 27'h0, "R14 flush with fill");
        fill_en = 1'b0;
        look(0, 10'h077, {27'h4444, 12'h3}, "R14 fill survives");
        look(0, 10'h040, {27'd600, 12'h0}, "R14 rest gone");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule